// File: doc/BRIEF.md
# Three-Level Carrier PWM Gate Generator

This block produces the twelve gate commands for a three-phase inverter in which every phase leg has four series switches and the DC bus is split by two capacitors into a positive rail, a neutral point and a negative rail. Each phase can therefore sit at one of three levels: positive, zero (clamped to the neutral point) or negative. Three signed sinusoidal phase references arrive from an outer controller. One shared offset is added to each of them. The shifted references are then compared with two stacked triangular carriers, and the comparison picks the level of each leg.

The offset comes from an integer proportional-integral regulator inside the block. Its input is the difference between the measured upper and lower capacitor voltages. Adding the same offset to all three references moves the neutral point current and pulls the two capacitor voltages back together. The regulator updates once per carrier period, at the carrier peak. Every level change goes through a blanking interval whose length is set at a port. During that interval the switch that is leaving turns off before the switch that is arriving turns on.

Top module: `npc3_gate_gen`

## Requirements
- R1: One shared up/down counter forms the upper carrier. It starts at 0 after reset, steps by one per clock up to PEAK and then back down to 0, so one period lasts 2*PEAK clocks. The lower carrier is the upper carrier minus PEAK, which keeps the two carriers in phase.
- R2: Each phase's shifted reference is its signed reference plus the current offset, saturated to the range [-PEAK, +PEAK].
- R3: A phase requests the positive level when its shifted reference is strictly above the upper carrier, and the negative level when it is strictly below the lower carrier. Otherwise it requests the zero level.
- R4: Phase p (a=0, b=1, c=2) drives gates[4p+k], where k=0..3 selects switches S1..S4 from the positive rail downward. The positive level turns on S1 and S2 (pattern 4'b0011). The zero level turns on S2 and S3 (4'b0110). The negative level turns on S3 and S4 (4'b1100).
- R5: When the requested level differs from the committed level and dead_cyc is nonzero, the gates show the AND of the old and new patterns for dead_cyc cycles, and then the new pattern. Requests made during that interval are ignored until it ends. When dead_cyc is 0, the new pattern appears at the next clock edge.
- R6: S1 and S3 of a phase are never on together, and neither are S2 and S4.
- R7: The regulator uses err = vc_hi - vc_lo. At each clock in which the carrier is at PEAK, it updates the integrator to sat(integ + floor(err/2^KI_SH), ±ILIM) and vofs to sat(floor(err/2^KP_SH) + new integ, ±PEAK). At all other times vofs holds its value.
- R8: A synchronous active-high reset turns all gates off, clears the integrator and vofs, and restarts the carrier. Each leg leaves reset in an all-off state, so the first level it takes is also reached through blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | W | Signed reference, phase a |
| ref_b | input | W | Signed reference, phase b |
| ref_c | input | W | Signed reference, phase c |
| vc_hi | input | W | Signed upper capacitor voltage sample |
| vc_lo | input | W | Signed lower capacitor voltage sample |
| dead_cyc | input | DW | Blanking length in clock cycles |
| gates | output | 12 | Gate commands, four per phase |
| vofs | output | W | Offset currently added to the references |

## Verification
A carrier counter that is off by even one count shifts the level decisions, and the error appears on the gates within one period near the crossings. A wrong integrator value shows on vofs at the next carrier peak and moves every edge of all three legs from that peak on. A blanking counter or committed level that is wrong produces either a pattern that is neither the old one, the new one nor their AND, or an interval of the wrong length. In both cases the gates differ from the expected pattern within dead_cyc+1 cycles of the level change.

// File: rtl/npc3_pkg.sv
package npc3_pkg;

  typedef enum logic [1:0] {
    LV_OFF  = 2'd0,
    LV_POS  = 2'd1,
    LV_ZERO = 2'd2,
    LV_NEG  = 2'd3
  } lvl_e;

  // switch pattern {S4,S3,S2,S1} for a leg level
  function automatic logic [3:0] lvl_gates(lvl_e lv);
    case (lv)
      LV_POS:  return 4'b0011;
      LV_ZERO: return 4'b0110;
      LV_NEG:  return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  // symmetric saturation to +/- lim
  function automatic int sat_sym(int v, int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/npc3_carrier.sv
module npc3_carrier #(
  parameter int PEAK = 500,
  localparam int CW = $clog2(PEAK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          at_peak
);
  logic rising;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(PEAK - 1)) rising <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) rising <= 1'b1;
    end
  end

  assign at_peak = (cnt == CW'(PEAK));

  assert_carrier_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(PEAK));
  assert_carrier_turn_R1: assert property (@(posedge clk) disable iff (rst)
    at_peak |=> (cnt == CW'(PEAK - 1)));

endmodule

// File: rtl/npc3_balance_pi.sv
module npc3_balance_pi
  import npc3_pkg::*;
#(
  parameter int W     = 12,
  parameter int PEAK  = 500,
  parameter int KP_SH = 2,
  parameter int KI_SH = 4,
  parameter int ILIM  = 250,
  localparam int IW   = W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  logic signed [W-1:0] vc_hi,
  input  logic signed [W-1:0] vc_lo,
  output logic signed [W-1:0] vofs
);
  logic signed [IW-1:0] integ;
  int err_i, integ_nx, ofs_nx;

  always_comb begin
    err_i    = int'(vc_hi) - int'(vc_lo);
    integ_nx = sat_sym(int'(integ) + (err_i >>> KI_SH), ILIM);
    ofs_nx   = sat_sym((err_i >>> KP_SH) + integ_nx, PEAK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ <= '0;
      vofs  <= '0;
    end else if (upd) begin
      integ <= IW'(integ_nx);
      vofs  <= W'(ofs_nx);
    end
  end

  assert_integ_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(integ) <= ILIM) && (int'(integ) >= -ILIM));
  assert_ofs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(vofs));

endmodule

// File: rtl/npc3_leg.sv
module npc3_leg
  import npc3_pkg::*;
#(
  parameter int W    = 12,
  parameter int PEAK = 500,
  parameter int DW   = 4,
  localparam int CW  = $clog2(PEAK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] ref_in,
  input  logic signed [W-1:0] offs,
  input  logic [CW-1:0]       cnt,
  input  logic [DW-1:0]       dead,
  output logic [3:0]          g
);
  int   sref, car_hi, car_lo;
  lvl_e lvl_want, lvl_cur, lvl_tgt;
  logic [DW-1:0] bcnt;
  logic blanking;

  always_comb begin
    sref   = sat_sym(int'(ref_in) + int'(offs), PEAK);
    car_hi = int'(cnt);
    car_lo = car_hi - PEAK;
    if (sref > car_hi)      lvl_want = LV_POS;
    else if (sref < car_lo) lvl_want = LV_NEG;
    else                    lvl_want = LV_ZERO;
  end

  assign blanking = (bcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_cur <= LV_OFF;
      lvl_tgt <= LV_OFF;
      bcnt    <= '0;
      g       <= '0;
    end else if (blanking) begin
      bcnt <= bcnt - 1'b1;
      if (bcnt == DW'(1)) begin
        lvl_cur <= lvl_tgt;
        g       <= lvl_gates(lvl_tgt);
      end
    end else if (lvl_want != lvl_cur) begin
      if (dead == '0) begin
        lvl_cur <= lvl_want;
        g       <= lvl_gates(lvl_want);
      end else begin
        lvl_tgt <= lvl_want;
        bcnt    <= dead;
        g       <= lvl_gates(lvl_cur) & lvl_gates(lvl_want);
      end
    end
  end

  assert_interlock_R6: assert property (@(posedge clk) disable iff (rst)
    !(g[0] && g[2]) && !(g[1] && g[3]));
  assert_break_before_make_R5: assert property (@(posedge clk) disable iff (rst)
    ((g & ~$past(g)) != 4'b0) |-> (((~g & $past(g)) == 4'b0) || ($past(dead) == '0)));

endmodule

// File: rtl/npc3_gate_gen.sv
module npc3_gate_gen
  import npc3_pkg::*;
#(
  parameter int W     = 12,
  parameter int PEAK  = 500,
  parameter int DW    = 4,
  parameter int KP_SH = 2,
  parameter int KI_SH = 4,
  parameter int ILIM  = 250,
  localparam int NPH  = 3,
  localparam int CW   = $clog2(PEAK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] ref_a,
  input  logic signed [W-1:0] ref_b,
  input  logic signed [W-1:0] ref_c,
  input  logic signed [W-1:0] vc_hi,
  input  logic signed [W-1:0] vc_lo,
  input  logic [DW-1:0]       dead_cyc,
  output logic [4*NPH-1:0]    gates,
  output logic signed [W-1:0] vofs
);
  logic [CW-1:0] car_cnt;
  logic          car_peak;
  logic signed [W-1:0] refs [NPH];

  assign refs[0] = ref_a;
  assign refs[1] = ref_b;
  assign refs[2] = ref_c;

  npc3_carrier #(.PEAK(PEAK)) u_car (
    .clk(clk), .rst(rst), .cnt(car_cnt), .at_peak(car_peak)
  );

  npc3_balance_pi #(
    .W(W), .PEAK(PEAK), .KP_SH(KP_SH), .KI_SH(KI_SH), .ILIM(ILIM)
  ) u_pi (
    .clk(clk), .rst(rst), .upd(car_peak),
    .vc_hi(vc_hi), .vc_lo(vc_lo), .vofs(vofs)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    npc3_leg #(.W(W), .PEAK(PEAK), .DW(DW)) u_leg (
      .clk(clk), .rst(rst), .ref_in(refs[p]), .offs(vofs),
      .cnt(car_cnt), .dead(dead_cyc), .g(gates[4*p +: 4])
    );
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> ((gates == '0) && (vofs == '0)));

endmodule

// File: tb/npc3_gate_gen_tb.sv
module npc3_gate_gen_tb;
  localparam int W = 12, PEAK = 500, DW = 4, KP_SH = 2, KI_SH = 4, ILIM = 250;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W-1:0] ref_a = '0, ref_b = '0, ref_c = '0, vc_hi = '0, vc_lo = '0;
  logic [DW-1:0] dead_cyc = 4'd3;
  logic [11:0] gates;
  logic signed [W-1:0] vofs;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  npc3_gate_gen #(.W(W), .PEAK(PEAK), .DW(DW), .KP_SH(KP_SH), .KI_SH(KI_SH),
                  .ILIM(ILIM)) u_dut (
    .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .vc_hi(vc_hi), .vc_lo(vc_lo), .dead_cyc(dead_cyc), .gates(gates), .vofs(vofs)
  );

  // reference model: levels 0 off, 1 pos, 2 zero, 3 neg
  int m_cnt, m_integ, m_offs;
  bit m_up;
  int m_cur [3], m_tgt [3], m_bc [3];
  logic [3:0] m_g [3];

  function automatic int clampv(int v, int lim);
    return (v > lim) ? lim : ((v < -lim) ? -lim : v);
  endfunction

  function automatic int floordiv(int x, int k);
    int d = 1 << k;
    if (x >= 0) return x / d;
    return -((-x + d - 1) / d);
  endfunction

  function automatic logic [3:0] pat(int lv);
    case (lv)
      1: return 4'b0011;
      2: return 4'b0110;
      3: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic model_step();
    int err, ni, no, sref, want;
    int rv [3];
    if (rst) begin
      m_cnt = 0; m_up = 1; m_integ = 0; m_offs = 0;
      for (int p = 0; p < 3; p++) begin
        m_cur[p] = 0; m_tgt[p] = 0; m_bc[p] = 0; m_g[p] = 4'b0;
      end
      return;
    end
    rv[0] = int'(ref_a); rv[1] = int'(ref_b); rv[2] = int'(ref_c);
    for (int p = 0; p < 3; p++) begin
      sref = clampv(rv[p] + m_offs, PEAK);
      if (sref > m_cnt) want = 1;
      else if (sref < m_cnt - PEAK) want = 3;
      else want = 2;
      if (m_bc[p] != 0) begin
        if (m_bc[p] == 1) begin
          m_cur[p] = m_tgt[p];
          m_g[p] = pat(m_tgt[p]);
        end
        m_bc[p] = m_bc[p] - 1;
      end else if (want != m_cur[p]) begin
        if (dead_cyc == 0) begin
          m_cur[p] = want;
          m_g[p] = pat(want);
        end else begin
          m_g[p] = pat(m_cur[p]) & pat(want);
          m_tgt[p] = want;
          m_bc[p] = int'(dead_cyc);
        end
      end
    end
    if (m_cnt == PEAK) begin
      err = int'(vc_hi) - int'(vc_lo);
      ni = clampv(m_integ + floordiv(err, KI_SH), ILIM);
      no = clampv(floordiv(err, KP_SH) + ni, PEAK);
      m_integ = ni;
      m_offs = no;
    end
    if (m_up) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == PEAK) m_up = 0;
    end else begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) m_up = 1;
    end
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    check(gates == {m_g[2], m_g[1], m_g[0]}, "R1 R2 R3 R4 R5 gate pattern",
          int'(gates), int'({m_g[2], m_g[1], m_g[0]}));
    for (int p = 0; p < 3; p++)
      check(!(gates[4*p] && gates[4*p+2]) && !(gates[4*p+1] && gates[4*p+3]),
            "R6 interlock", int'(gates), 0);
    check(int'(vofs) == m_offs, "R7 offset", int'(vofs), m_offs);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  function automatic logic signed [W-1:0] rnd_s(int span);
    int v = int'($urandom_range(2 * span)) - span;
    return W'(v);
  endfunction

  initial begin
    void'($urandom(32'd20240912));
    // R8: reset clears everything
    run(4);
    check(gates == 12'h000, "R8 reset gates", int'(gates), 0);
    check(vofs == '0, "R8 reset offset", int'(vofs), 0);
    rst = 1'b0;
    // zero references, balanced bus: all legs settle at the zero level
    run(1200);
    check(gates == 12'h666, "R4 zero level", int'(gates), 'h666);
    // saturated positive and negative references
    ref_a = 12'sd700; ref_b = 12'sd700; ref_c = 12'sd700;
    run(1000);
    ref_a = -12'sd700; ref_b = -12'sd700; ref_c = -12'sd700;
    run(1000);
    // R7: heavy imbalance drives the offset to its positive limit
    ref_a = '0; ref_b = '0; ref_c = '0;
    vc_hi = 12'sd2047; vc_lo = -12'sd2048;
    run(4000);
    check(int'(vofs) == PEAK, "R7 offset positive limit", int'(vofs), PEAK);
    vc_hi = -12'sd2048; vc_lo = 12'sd2047;
    run(6000);
    check(int'(vofs) == -PEAK, "R7 offset negative limit", int'(vofs), -PEAK);
    // random mix
    vc_hi = '0; vc_lo = '0;
    for (int i = 0; i < 800; i++) begin
      if (i % 10 == 0) begin
        vc_hi = rnd_s(200);
        vc_lo = rnd_s(200);
      end
      if (i % 60 == 0) dead_cyc = DW'($urandom_range(15));
      ref_a = rnd_s(600); ref_b = rnd_s(600); ref_c = rnd_s(600);
      run(50);
    end
    // R5: no blanking, direct transitions
    dead_cyc = '0;
    for (int i = 0; i < 100; i++) begin
      ref_a = rnd_s(550); ref_b = rnd_s(550); ref_c = rnd_s(550);
      run(50);
    end
    // R8: reset again in the middle of operation
    rst = 1'b1;
    run(2);
    check(gates == 12'h000, "R8 mid-run reset gates", int'(gates), 0);
    check(vofs == '0, "R8 mid-run reset offset", int'(vofs), 0);
    rst = 1'b0;
    dead_cyc = 4'd15;
    ref_a = 12'sd300; ref_b = -12'sd300; ref_c = 12'sd0;
    run(3000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule